// File: doc/BRIEF.md
# I2C Slave Address Listener and Byte Receiver

This block is the receive half of an I2C target. It watches the two bus lines, finds a START condition and shifts in the byte that follows it, most significant bit first. The upper seven bits of that byte are checked against a programmed seven-bit own address. The all-zero address is treated as a general call. Either kind of hit sets its own status flag and gives a one-cycle interrupt pulse. Any other address puts the block to sleep until the next START.

Once the block is addressed, it takes bytes one at a time. After each byte, including the address byte, it waits for the host to make a one-cycle dummy write before it accepts the next byte. It presents each received data byte with a one-cycle valid strobe. In acknowledge mode the block pulls SDA low for the acknowledge clock. In silent mode it never drives the line. A STOP condition ends the transfer.

Top module: `i2c_slave_rx`

## Requirements
- R1: While reset is high and on the first cycle after it, sda_pull, gc_flag, aas_flag, irq and rx_valid are all 0.
- R2: When bits [7:1] of the first byte after a START equal own_addr and are not all zero, aas_flag goes to 1, gc_flag stays 0, and irq pulses high for exactly one cycle.
- R3: When bits [7:1] of the first byte after a START are all zero, gc_flag goes to 1, aas_flag stays 0, and irq pulses high for exactly one cycle.
- R4: Any other address leaves both flags at 0, gives no irq pulse and no acknowledge, and ignores every later byte (no rx_valid, no acknowledge) until the next START.
- R5: With ack_en=1, sda_pull is 1 across the ninth SCL clock after a matched address and after each accepted data byte. With ack_en=0, sda_pull stays 0.
- R6: Data bits are sampled on SCL rising edges, MSB first. Each accepted data byte appears on rx_data together with a one-cycle rx_valid pulse.
- R7: After any byte, the block ignores further SCL clocks until a one-cycle host_wr pulse arrives. A byte clocked in before that pulse is neither received nor acknowledged.
- R8: Both flags return to 0 on a STOP (SDA rising while SCL is high) and on a repeated START (SDA falling while SCL is high).
- R9: gc_flag and aas_flag are never both 1. sda_pull is 1 only while one of the flags is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line level (asynchronous) |
| sda_in | input | 1 | SDA line level (asynchronous) |
| own_addr | input | 7 | Programmed own address |
| ack_en | input | 1 | 1 = acknowledge mode, 0 = silent mode |
| host_wr | input | 1 | One-cycle dummy write that releases the next byte |
| sda_pull | output | 1 | 1 = drive SDA low (open-drain enable) |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| gc_flag | output | 1 | General-call address recognised |
| aas_flag | output | 1 | Own address recognised |
| irq | output | 1 | One-cycle pulse on address recognition |

## Verification
A wrong state in the receive sequencer is visible at the ports within one byte time. It shows up as an acknowledge bit that is missing or extra, or as a data byte that was accepted without a dummy write. A fault in the bit counter or the shift register gives an rx_data value that is rotated or shifted, already at the first data byte. A fault in flag handling shows up as a flag that is still set after a STOP or a repeated START, or as an irq pulse count that differs from the number of recognised addresses, and this is caught at the end of the same transaction.

// File: rtl/i2c_slave_rx_pkg.sv
package i2c_slave_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_WAIT_FALL,
    ST_ACK_LO,
    ST_ACK_HI,
    ST_HOLD,
    ST_IGNORE
  } rx_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_rx_shifter.sv
module i2c_rx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [DATA_W-1:0] data,
  output logic              full
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt  <= '0;
      data <= '0;
    end else if (shift_en && !full) begin
      cnt  <= cnt + 1'b1;
      data <= {data[DATA_W-2:0], bit_in};
    end
  end

  assign full = (cnt == CNT_W'(DATA_W));
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_en,
  input  logic              host_wr,
  output logic              sda_pull,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              gc_flag,
  output logic              aas_flag,
  output logic              irq
);
  import i2c_slave_rx_pkg::*;

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, sync_lines;
  logic scl_s, sda_s, scl_q, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;
  rx_state_t state;
  logic [DATA_W-1:0] sh_data;
  logic sh_full, sh_clear, sh_en;
  logic [ADDR_W-1:0] rx_addr;

  assign raw_lines = {sda_in, scl_in};

  genvar i;
  generate
    for (i = 0; i < NLINES; i++) begin : g_sync
      i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (raw_lines[i]),
        .dout(sync_lines[i])
      );
    end
  endgenerate

  assign scl_s = sync_lines[0];
  assign sda_s = sync_lines[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s && !scl_q;
  assign scl_fall  = !scl_s && scl_q;
  assign start_det = scl_s && scl_q && sda_q && !sda_s;
  assign stop_det  = scl_s && scl_q && !sda_q && sda_s;

  assign sh_clear = start_det || (state == ST_HOLD && host_wr);
  assign sh_en    = scl_rise && (state == ST_ADDR || state == ST_DATA);

  i2c_rx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .clear   (sh_clear),
    .shift_en(sh_en),
    .bit_in  (sda_s),
    .data    (sh_data),
    .full    (sh_full)
  );

  assign rx_addr = sh_data[DATA_W-1 -: ADDR_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      sda_pull <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      gc_flag  <= 1'b0;
      aas_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      irq      <= 1'b0;
      if (start_det) begin
        state    <= ST_ADDR;
        sda_pull <= 1'b0;
        gc_flag  <= 1'b0;
        aas_flag <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
        gc_flag  <= 1'b0;
        aas_flag <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: if (sh_full) begin
            if (rx_addr == '0) begin
              gc_flag <= 1'b1;
              irq     <= 1'b1;
              state   <= ST_WAIT_FALL;
            end else if (rx_addr == own_addr) begin
              aas_flag <= 1'b1;
              irq      <= 1'b1;
              state    <= ST_WAIT_FALL;
            end else begin
              state <= ST_IGNORE;
            end
          end
          ST_DATA: if (sh_full) begin
            rx_data  <= sh_data;
            rx_valid <= 1'b1;
            state    <= ST_WAIT_FALL;
          end
          ST_WAIT_FALL: if (scl_fall) begin
            sda_pull <= ack_en;
            state    <= ST_ACK_LO;
          end
          ST_ACK_LO: if (scl_rise) state <= ST_ACK_HI;
          ST_ACK_HI: if (scl_fall) begin
            sda_pull <= 1'b0;
            state    <= ST_HOLD;
          end
          ST_HOLD: if (host_wr) state <= ST_DATA;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_slave_rx_chk.sv
module i2c_slave_rx_chk (
  input logic clk,
  input logic rst,
  input logic sda_pull,
  input logic rx_valid,
  input logic gc_flag,
  input logic aas_flag,
  input logic irq
);
  // R1: outputs idle on the cycle after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!sda_pull && !gc_flag && !aas_flag && !irq && !rx_valid));

  // R9: the two recognition flags are exclusive
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(gc_flag && aas_flag));

  // R9: SDA is driven only while addressed
  a_r9_pull_needs_flag: assert property (@(posedge clk) disable iff (rst)
    sda_pull |-> (gc_flag || aas_flag));

  // R2 / R3: interrupt comes with a recognition flag and lasts one cycle
  a_r2_irq_with_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> (gc_flag || aas_flag));

  a_r3_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R6: data strobe is a single-cycle pulse
  a_r6_valid_single: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

bind i2c_slave_rx i2c_slave_rx_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .sda_pull(sda_pull),
  .rx_valid(rx_valid),
  .gc_flag (gc_flag),
  .aas_flag(aas_flag),
  .irq     (irq)
);

// File: tb/i2c_slave_rx_test.sv
module i2c_slave_rx_test;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [6:0] own_addr = 7'h2A;
  logic ack_en = 1'b1;
  logic host_wr = 1'b0;
  logic sda_pull, rx_valid, gc_flag, aas_flag, irq;
  logic [7:0] rx_data;
  logic sda_line;

  int n_tests = 0, n_fail = 0;
  int irq_cnt = 0, rx_cnt = 0;
  logic [7:0] last_rx = 8'h00;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  i2c_slave_rx uut (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
    .own_addr(own_addr), .ack_en(ack_en), .host_wr(host_wr),
    .sda_pull(sda_pull), .rx_data(rx_data), .rx_valid(rx_valid),
    .gc_flag(gc_flag), .aas_flag(aas_flag), .irq(irq)
  );

  always @(posedge clk) begin
    if (irq) irq_cnt <= irq_cnt + 1;
    if (rx_valid) begin
      rx_cnt  <= rx_cnt + 1;
      last_rx <= rx_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int k = 7; k >= 0; k--) begin
      sda_m = b[k]; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0;
    end
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H / 2);
    acked = (sda_line == 1'b0);
    wt(H / 2); scl_m = 1'b0; wt(H);
  endtask

  task automatic dummy_write();
    host_wr = 1'b1; wt(1); host_wr = 1'b0; wt(2);
  endtask

  function automatic int kind_of(input logic [7:0] a, input logic [6:0] own);
    if (a[7:1] == 7'd0) return 1;
    if (a[7:1] == own)  return 2;
    return 0;
  endfunction

  initial begin : watchdog
    #3000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    bit ack;
    int i0, r0;
    logic [7:0] a, d;
    int kind;
    wt(4);
    chk(!sda_pull && !gc_flag && !aas_flag && !irq && !rx_valid, "R1 reset outputs", 0, 0);
    rst = 1'b0; wt(2);
    chk(!sda_pull && !gc_flag && !aas_flag, "R1 after reset", {sda_pull, gc_flag, aas_flag}, 0);

    // directed: match without dummy write then with
    i0 = irq_cnt; r0 = rx_cnt;
    bus_start(); send_byte({7'h2A, 1'b0}, ack);
    chk(aas_flag && !gc_flag, "R2 own match flag", {gc_flag, aas_flag}, 1);
    chk(irq_cnt == i0 + 1, "R2 irq count", irq_cnt - i0, 1);
    chk(ack, "R5 ack on address", ack, 1);
    send_byte(8'hA5, ack);
    chk(!ack && rx_cnt == r0, "R7 byte before dummy write ignored", rx_cnt - r0, 0);
    dummy_write(); send_byte(8'h3C, ack);
    chk(ack && rx_cnt == r0 + 1 && last_rx == 8'h3C, "R6 data byte", last_rx, 8'h3C);
    // repeated start clears flags
    bus_start();
    chk(!aas_flag && !gc_flag, "R8 repeated start clears", {gc_flag, aas_flag}, 0);
    send_byte({7'h11, 1'b0}, ack);
    chk(!ack && !aas_flag && !gc_flag, "R4 mismatch no ack", ack, 0);
    dummy_write(); r0 = rx_cnt; send_byte(8'h77, ack);
    chk(!ack && rx_cnt == r0, "R4 data ignored after mismatch", rx_cnt - r0, 0);
    bus_stop();

    // directed: general call in silent mode, stop clears
    ack_en = 1'b0; i0 = irq_cnt;
    bus_start(); send_byte(8'h00, ack);
    chk(gc_flag && !aas_flag && irq_cnt == i0 + 1, "R3 general call", {gc_flag, aas_flag}, 2);
    chk(!ack, "R5 no ack in silent mode", ack, 0);
    dummy_write(); send_byte(8'h81, ack);
    chk(!ack && last_rx == 8'h81, "R6 silent data", last_rx, 8'h81);
    bus_stop();
    chk(!gc_flag && !aas_flag, "R8 stop clears", {gc_flag, aas_flag}, 0);

    // random transactions
    void'($urandom(32'h1234));
    for (int t = 0; t < 30; t++) begin
      own_addr = 7'($urandom_range(1, 127));
      ack_en = 1'($urandom_range(0, 1));
      case ($urandom_range(0, 2))
        0: a = {own_addr, 1'b0};
        1: a = 8'h00;
        default: begin
          a = 8'($urandom);
          while (a[7:1] == own_addr || a[7:1] == 7'd0) a = 8'($urandom);
        end
      endcase
      kind = kind_of(a, own_addr);
      i0 = irq_cnt;
      bus_start(); send_byte(a, ack);
      chk(gc_flag == (kind == 1) && aas_flag == (kind == 2), "R2 R3 R4 random flags", {gc_flag, aas_flag}, kind);
      chk(irq_cnt - i0 == (kind != 0 ? 1 : 0), "R2 random irq", irq_cnt - i0, kind != 0);
      chk(ack == (ack_en && kind != 0), "R5 random addr ack", ack, ack_en && kind != 0);
      for (int b = 0; b < int'($urandom_range(1, 3)); b++) begin
        d = 8'($urandom); r0 = rx_cnt;
        dummy_write(); send_byte(d, ack);
        if (kind != 0) begin
          chk(rx_cnt == r0 + 1 && last_rx == d, "R6 random data", last_rx, d);
          chk(ack == ack_en, "R5 random data ack", ack, ack_en);
        end else begin
          chk(rx_cnt == r0 && !ack, "R4 random ignored", rx_cnt - r0, 0);
        end
      end
      bus_stop();
      chk(!gc_flag && !aas_flag && !sda_pull, "R8 random stop", {gc_flag, aas_flag}, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule